// File: doc/BRIEF.md
# Multiplexed-Bus External Data Memory Target

This block is the memory side of a shared 8-bit address/data bus. A bus master places an address on the bus while pulsing an address strobe, then either pulses an active-low read strobe, during which the target returns a byte, or an active-low write strobe, during which the target takes a byte from the bus. The target separates the address from the data phase with its own latch and holds 256 bytes in a synchronous RAM that block RAM can implement.

All strobes are sampled on the system clock, and edges are found by comparing each sample with the one before it. The address is taken when the address strobe is seen to fall. A write is committed when the write strobe is seen to rise. During a read the block drives its output enable from the first clock after the read strobe goes low. It releases the bus as soon as the read strobe returns high. The bus value seen by the block is the wired result of the master's driver and the block's driver.

Top module: `mbus_xmem_target`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bus_oe_o` is 0 regardless of `rd_n_i`.
- R2: On a falling edge of `ale_i`, the latched address becomes the bus value from the last clock sample in which `ale_i` was still high. A bus change made together with the fall of `ale_i` is not captured.
- R3: On a rising edge of `wr_n_i`, the byte at the latched address becomes the bus value from the last clock sample in which `wr_n_i` was still low. A bus change made together with the rise of `wr_n_i` is not stored.
- R4: While `rd_n_i` is low, `bus_o` carries the byte stored at the latched address. It is valid from the third clock edge after `rd_n_i` is sampled low, provided the address strobe fell at least two clocks before the read strobe.
- R5: `bus_oe_o` is 0 before the first clock edge that samples `rd_n_i` low, and 1 after that edge for as long as `rd_n_i` stays low.
- R6: `bus_oe_o` is 0 whenever `rd_n_i` is high. It falls in the same cycle that `rd_n_i` rises, with no clock edge in between.
- R7: The latched address changes only on an `ale_i` falling edge. A read or write strobe with no new address strobe reuses the last address.
- R8: Each of the 256 locations keeps its own byte, so a pattern written to every address reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address strobe, active high; address taken on its fall |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; data committed on its rise |
| bus_i | input | 8 | Resolved value of the shared bus |
| bus_o | output | 8 | Byte the block drives during a read |
| bus_oe_o | output | 1 | Output enable for `bus_o` onto the shared bus |

## Verification
The bench builds the block with its default widths: an 8-bit bus and an 8-bit address, which gives a 256-byte array. At that size a full write-then-read sweep of every location fits in a few thousand cycles, so aliasing between addresses is exposed, not only a few hand-picked cases. The bench also moves the bus to a different value together with each falling address strobe and each rising write strobe, so capturing one sample too late shows up as a miscompare. It watches its own driver against `bus_oe_o` on every cycle to catch both sides driving at once.

// File: rtl/mbus_xmem_pkg.sv
package mbus_xmem_pkg;

  localparam int unsigned MBX_ADDR_W = 8;
  localparam int unsigned MBX_DATA_W = 8;

  // Strobes that need edge detection; read strobe is handled level-wise.
  typedef struct packed {
    logic ale;
    logic wr_n;
  } mbx_strobe_t;

  localparam mbx_strobe_t MBX_STROBE_IDLE = '{ale: 1'b0, wr_n: 1'b1};

endpackage

// File: rtl/mbus_strobe_sampler.sv
module mbus_strobe_sampler
  import mbus_xmem_pkg::*;
#(
  parameter int unsigned DATA_W = MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mbx_strobe_t       strb_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ale_fall_o,
  output logic              wr_rise_o,
  output logic [DATA_W-1:0] bus_prev_o
);

  mbx_strobe_t       cur_q, prev_q;
  logic [DATA_W-1:0] bus_cur_q, bus_prev_q;

  // Two sample stages: the older one pairs the bus with the last
  // strobe level seen before an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= MBX_STROBE_IDLE;
      prev_q     <= MBX_STROBE_IDLE;
      bus_cur_q  <= '0;
      bus_prev_q <= '0;
    end else begin
      cur_q      <= strb_i;
      prev_q     <= cur_q;
      bus_cur_q  <= bus_i;
      bus_prev_q <= bus_cur_q;
    end
  end

  assign ale_fall_o = prev_q.ale & ~cur_q.ale;
  assign wr_rise_o  = ~prev_q.wr_n & cur_q.wr_n;
  assign bus_prev_o = bus_prev_q;

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/mbus_byte_ram.sv
module mbus_byte_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // Single port, read-first, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mbus_xmem_target.sv
module mbus_xmem_target
  import mbus_xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = MBX_ADDR_W,
  parameter int unsigned DATA_W = MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  localparam int unsigned ADDR_FROM_BUS = (ADDR_W <= DATA_W) ? ADDR_W : DATA_W;

  mbx_strobe_t       strb;
  logic              ale_fall;
  logic              wr_rise;
  logic [DATA_W-1:0] bus_smp;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;
  logic [DATA_W-1:0] rdata;
  logic              rd_act_q;

  assign strb.ale  = ale_i;
  assign strb.wr_n = wr_n_i;

  mbus_strobe_sampler #(.DATA_W(DATA_W)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .strb_i     (strb),
    .bus_i      (bus_i),
    .ale_fall_o (ale_fall),
    .wr_rise_o  (wr_rise),
    .bus_prev_o (bus_smp)
  );

  always_comb begin
    addr_next = '0;
    addr_next[ADDR_FROM_BUS-1:0] = bus_smp[ADDR_FROM_BUS-1:0];
  end

  mbus_addr_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .load_i (ale_fall),
    .addr_i (addr_next),
    .addr_o (addr_q)
  );

  mbus_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we_i    (wr_rise),
    .addr_i  (addr_q),
    .wdata_i (bus_smp),
    .rdata_o (rdata)
  );

  // Read strobe registered once to turn the driver on; the raw strobe
  // gates it off so the bus is released without waiting for a clock.
  always_ff @(posedge clk) begin
    if (rst) rd_act_q <= 1'b0;
    else     rd_act_q <= ~rd_n_i;
  end

  assign bus_oe_o = rd_act_q & ~rd_n_i;
  assign bus_o    = rdata;

endmodule

// File: rtl/mbus_xmem_target_chk.sv
module mbus_xmem_target_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_n_i,
  input logic              bus_oe_o,
  input logic              ale_fall,
  input logic [DATA_W-1:0] bus_smp,
  input logic [ADDR_W-1:0] addr_q
);

  AST_RST_RELEASES_BUS: assert property (@(posedge clk)
    rst |=> !bus_oe_o); // R1

  AST_ADDR_FROM_LAST_HIGH: assert property (@(posedge clk) disable iff (rst)
    ale_fall |=> (addr_q == $past(bus_smp[ADDR_W-1:0]))); // R2

  AST_OE_AFTER_RD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_i && $past(!rd_n_i) && $past(!rst)) |-> bus_oe_o); // R5

  AST_FLOAT_WHEN_RD_HIGH: assert property (@(posedge clk) disable iff (rst)
    rd_n_i |-> !bus_oe_o); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    !ale_fall |=> $stable(addr_q)); // R7

endmodule

bind mbus_xmem_target mbus_xmem_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_n_i   (rd_n_i),
  .bus_oe_o (bus_oe_o),
  .ale_fall (ale_fall),
  .bus_smp  (bus_smp),
  .addr_q   (addr_q)
);

// File: tb/tb_mbus_xmem_target.sv
module tb_mbus_xmem_target;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic          drv_en = 1'b0;
  logic [DW-1:0] drv = '0;
  logic [DW-1:0] bus_w, dut_bus;
  logic          dut_oe;

  int   checks = 0, fails = 0, clashes = 0;
  bit   done = 1'b0;
  event smp_ev;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk; // 50 MHz

  assign bus_w = dut_oe ? dut_bus : (drv_en ? drv : 8'hFF);

  mbus_xmem_target #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .ale_i(ale), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .bus_i(bus_w), .bus_o(dut_bus), .bus_oe_o(dut_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 29 + 8'h5A) ^ DW'(i >> 3);
  endfunction

  // Address phase; the bus changes together with the ALE fall (R2).
  task automatic put_addr(input logic [DW-1:0] a);
    drv_en = 1'b1; drv = a; ale = 1'b1;
    cyc(2);
    ale = 1'b0; drv = ~a;
    cyc(1);
    drv_en = 1'b0;
    cyc(1);
  endtask

  // Data phase of a write; the bus changes together with the WR rise (R3).
  task automatic wr_data(input logic [DW-1:0] d);
    drv_en = 1'b1; drv = d;
    cyc(1);
    wr_n = 1'b0;
    cyc(2);
    wr_n = 1'b1; drv = ~d;
    cyc(1);
    drv_en = 1'b0;
    cyc(2);
  endtask

  // Data phase of a read: expected byte goes to the scoreboard.
  task automatic rd_data(input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    rd_n = 1'b0;
    #1 chk("R5 oe before first edge", {7'd0, dut_oe}, 8'd0);
    cyc(1);
    chk("R5 oe after first edge", {7'd0, dut_oe}, 8'd1);
    cyc(3);
    -> smp_ev;
    #1;
    rd_n = 1'b1;
    #1 chk("R6 release on rd high", {7'd0, dut_oe}, 8'd0);
    cyc(2);
  endtask

  // Monitor: pops the scoreboard when the driver signals a sample point.
  initial forever begin
    @(smp_ev);
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R4: actual %h expected none (empty scoreboard)", bus_w);
    end else begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (!dut_oe || bus_w !== e) begin
        fails++;
        $display("FAIL %s: actual %h (oe %0b) expected %h", t, bus_w, dut_oe, e);
      end
    end
  end

  // Contention watch: master and target must never drive together.
  always @(negedge clk) if (drv_en && dut_oe) clashes++;

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: read strobe held low across reset
    rd_n = 1'b0;
    cyc(3);
    chk("R1 oe in reset", {7'd0, dut_oe}, 8'd0);
    rst = 1'b0;
    #1 chk("R1 oe after reset", {7'd0, dut_oe}, 8'd0);
    rd_n = 1'b1;
    cyc(2);

    // R2/R3/R4: basic write then read, distinct patterns
    put_addr(8'h3C); wr_data(8'hA5);
    put_addr(8'hC3); wr_data(8'h5A);
    put_addr(8'h3C); rd_data(8'hA5, "R2 R3 R4 read 3C");
    put_addr(8'hC3); rd_data(8'h5A, "R2 R3 R4 read C3");
    put_addr(8'h00); wr_data(8'h01);
    put_addr(8'hFF); wr_data(8'hFE);
    put_addr(8'h00); rd_data(8'h01, "R4 boundary 00");
    put_addr(8'hFF); rd_data(8'hFE, "R4 boundary FF");

    // R7: strobes without a new ALE reuse the last address (FF)
    rd_data(8'hFE, "R7 stray read");
    wr_data(8'h77);
    rd_data(8'h77, "R7 stray write then read");
    put_addr(8'h00); rd_data(8'h01, "R7 other address untouched");

    // R8: full sweep
    for (int i = 0; i < N; i++) begin
      put_addr(DW'(i)); wr_data(pat(i));
    end
    for (int i = 0; i < N; i++) begin
      put_addr(DW'(i)); rd_data(pat(i), "R8 sweep");
    end

    cyc(4);
    chk("R6 no bus contention count", DW'(clashes), 8'd0);
    chk("R4 scoreboard drained", DW'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule